// File: doc/BRIEF.md
# Error-Correcting Word Store with Background Refresh

This block is a single-port, word-wide synchronous storage array protected by a single-error-correcting, double-error-detecting Hamming code. A user write encodes the data word into a codeword, permutes the codeword bits across the physical cells of the row and stores it. A user read returns the data one cycle later, with correction applied and with flags that report whether a single error was repaired or an uncorrectable error was seen. A user read never writes the array.

A background refresher can be switched on with a configuration input. It walks every address in ascending order. At each address it reads the word, and if the word holds a correctable error it writes back the repaired codeword. This keeps latent single upsets from pairing up into uncorrectable ones. User traffic always owns the port. The refresher waits on its current address until the port is free. A programmable number of idle cycles separates successive word visits. The refresher keeps saturating tallies of repaired and uncorrectable words, latches the address of the last uncorrectable word it found, and pulses a flag when a pass over the whole array completes.

A fault-injection mask on the write path lets a test flip chosen physical cells of the stored word. This stands in for upsets in the cell array.

Top module: `ecc_scrub_mem`

## Requirements
- R1: A read of a word stored with exactly one flipped physical cell returns the written data, with `rd_sbe`=1 and `rd_dbe`=0.
- R2: A read of a word stored with exactly two flipped physical cells gives `rd_dbe`=1 and `rd_sbe`=0.
- R3: A read of a word stored with no flipped cell returns the written data with both flags at 0.
- R4: When a read request is sampled on a rising edge, `rd_valid` and the read results appear after the next rising edge. `rd_valid` is 0 in every other cycle, and both flags are 0 whenever `rd_valid` is 0.
- R5: Logical codeword bit i is stored in physical cell (i*8) mod 39, and `usr_inj` bit p flips physical cell p. Two neighbouring physical cells therefore hold logical bits five apart, and flipping two such neighbours is reported as uncorrectable, never miscorrected.
- R6: A user read that repairs a single error leaves the array unchanged, so a second read of the same word again gives `rd_sbe`=1.
- R7: With `scrub_en`=1 the refresher visits every address. After a full pass, every word that held a single error reads back clean.
- R8: A user request always wins the port. The refresher stalls on its current address and skips none, even under dense read traffic.
- R9: In each visit the refresher counts `scrub_gap` idle cycles and then reads on the next idle cycle. With no errors and no traffic, a clean word takes `scrub_gap`+2 cycles, so `sweep_done` pulses for one cycle every DEPTH*(`scrub_gap`+2) cycles.
- R10: `fix_count` counts the single-error words the refresher finds and `bad_count` counts the uncorrectable ones. Each saturates at 2^CNT_W-1.
- R11: When `count_clr` is sampled high, both tallies read 0 after that edge. Clearing wins over counting.
- R12: A word the refresher finds uncorrectable is not rewritten and still reads as uncorrectable. Its address is latched into `bad_addr`.
- R13: After reset, `rd_valid`, `sweep_done`, both tallies and `bad_addr` are 0, and the refresher starts at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usr_req | input | 1 | User access request |
| usr_we | input | 1 | 1 = write, 0 = read |
| usr_addr | input | AW (7) | User word address |
| usr_wdata | input | DATA_W (32) | Write data |
| usr_inj | input | CW_W (39) | Physical cells to flip on this write (test injection) |
| rd_valid | output | 1 | Read results valid |
| rd_data | output | DATA_W (32) | Corrected read data |
| rd_sbe | output | 1 | Single error was corrected |
| rd_dbe | output | 1 | Uncorrectable error detected |
| scrub_en | input | 1 | Enable background refresh |
| scrub_gap | input | IVL_W (16) | Idle cycles counted before each word visit |
| count_clr | input | 1 | Clear both refresh tallies |
| fix_count | output | CNT_W (16) | Saturating count of repaired words |
| bad_count | output | CNT_W (16) | Saturating count of uncorrectable words |
| bad_addr | output | AW (7) | Address of last uncorrectable word found by refresh |
| sweep_done | output | 1 | One-cycle pulse after the last address is visited |

## Verification
A read request sampled on edge n has its data and flags due after edge n+1. The bench records each sampled request at the rising edge and compares `rd_valid`, the flags and the data at the following falling edge against a behavioural model of stored data and injected flip counts. Tallies and `bad_addr` change on the edge that closes the check cycle of a visit, and `count_clr` takes effect on the edge that samples it. The bench therefore reads them only at falling edges after the sweep pulse or the clear. The refresh period is measured as the number of rising edges between two `sweep_done` pulses. The refresher is turned off on the falling edge that shows the pulse, so no further word is visited.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

  localparam int MAX_CW = 256;

  // smallest number of check bits that covers data plus checks plus position 0
  function automatic int chk_bits(input int dw);
    for (int p = 1; p < 16; p++) begin
      if ((1 << p) >= dw + p + 1) return p;
    end
    return 16;
  endfunction

  // Hamming position carries payload when it is not a power of two
  function automatic bit is_data(input int pos);
    return (pos >= 3) && ((pos & (pos - 1)) != 0);
  endfunction

  // payload index held at a payload position
  function automatic int data_of(input int pos);
    return pos - 1 - $clog2(pos + 1);
  endfunction

  // positions whose index has bit k set
  function automatic logic [MAX_CW-1:0] cover_mask(input int k);
    logic [MAX_CW-1:0] m;
    m = '0;
    for (int i = 1; i < MAX_CW; i++) begin
      if (((i >> k) & 1) == 1) m[i] = 1'b1;
    end
    return m;
  endfunction

  typedef enum logic [1:0] {
    SW_WAIT  = 2'd0,
    SW_CHECK = 2'd1,
    SW_FIX   = 2'd2
  } sweep_st_e;

endpackage

// File: rtl/ecc_encode.sv
module ecc_encode
  import ecc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CHK_W  = 6,
  parameter int CW_W   = DATA_W + CHK_W + 1
) (
  input  logic [DATA_W-1:0] data,
  output logic [CW_W-1:0]   cw
);

  logic [CW_W-1:0] body;
  logic [CHK_W-1:0] chk;
  logic [CW_W-1:1] hi;

  // scatter payload onto non-power positions
  for (genvar i = 0; i < CW_W; i++) begin : g_body
    if (is_data(i)) begin : g_d
      assign body[i] = data[data_of(i)];
    end else begin : g_z
      assign body[i] = 1'b0;
    end
  end

  for (genvar k = 0; k < CHK_W; k++) begin : g_chk
    localparam logic [MAX_CW-1:0] MK = cover_mask(k);
    assign chk[k] = ^(body & MK[CW_W-1:0]);
  end

  for (genvar i = 1; i < CW_W; i++) begin : g_hi
    if (is_data(i)) begin : g_d
      assign hi[i] = body[i];
    end else begin : g_c
      assign hi[i] = chk[$clog2(i)];
    end
  end

  // position 0 holds even parity over the whole word
  assign cw = {hi, ^hi};

endmodule

// File: rtl/ecc_decode.sv
module ecc_decode
  import ecc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CHK_W  = 6,
  parameter int CW_W   = DATA_W + CHK_W + 1
) (
  input  logic [CW_W-1:0]   cw,
  output logic [CW_W-1:0]   fixed,
  output logic [DATA_W-1:0] data,
  output logic              sbe,
  output logic              dbe
);

  logic [CHK_W-1:0] syn;
  logic             par;
  logic             fixable;

  always_comb begin
    syn = '0;
    for (int i = 1; i < CW_W; i++) begin
      if (cw[i]) syn = syn ^ CHK_W'(i);
    end
  end

  assign par     = ^cw;
  assign fixable = par && (32'(syn) < CW_W);
  assign fixed   = fixable ? (cw ^ ({{(CW_W-1){1'b0}}, 1'b1} << syn)) : cw;
  assign sbe     = fixable;
  assign dbe     = !fixable && (par || (syn != '0));

  for (genvar i = 1; i < CW_W; i++) begin : g_out
    if (is_data(i)) begin : g_d
      assign data[data_of(i)] = fixed[i];
    end
  end

endmodule

// File: rtl/ecc_interleave.sv
module ecc_interleave #(
  parameter int CW_W   = 39,
  parameter int STRIDE = 8,
  parameter bit UNDO   = 1'b0
) (
  input  logic [CW_W-1:0] din,
  output logic [CW_W-1:0] dout
);

  // logical bit i lives in physical cell (i*STRIDE) mod CW_W; STRIDE coprime to CW_W
  for (genvar i = 0; i < CW_W; i++) begin : g_map
    localparam int PC = (i * STRIDE) % CW_W;
    if (UNDO) begin : g_rd
      assign dout[i] = din[PC];
    end else begin : g_wr
      assign dout[PC] = din[i];
    end
  end

endmodule

// File: rtl/ecc_store.sv
module ecc_store #(
  parameter int CW_W  = 39,
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            we,
  input  logic            re,
  input  logic [AW-1:0]   addr,
  input  logic [CW_W-1:0] wdata,
  output logic [CW_W-1:0] rdata
);

  logic [CW_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
    if (re) rdata <= cells[addr];
  end

endmodule

// File: rtl/ecc_sweeper.sv
module ecc_sweeper
  import ecc_pkg::*;
#(
  parameter int CW_W  = 39,
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH),
  parameter int IVL_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [IVL_W-1:0] gap,
  input  logic             busy,
  input  logic             busy_we,
  input  logic [AW-1:0]    busy_addr,
  input  logic             dec_sbe,
  input  logic             dec_dbe,
  input  logic [CW_W-1:0]  dec_cw,
  input  logic             clr,
  output logic             rd_go,
  output logic             wr_go,
  output logic [AW-1:0]    addr,
  output logic [CW_W-1:0]  wr_cw,
  output logic [CNT_W-1:0] fix_cnt,
  output logic [CNT_W-1:0] bad_cnt,
  output logic [AW-1:0]    bad_addr,
  output logic             done
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  sweep_st_e        st_q, st_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic [IVL_W-1:0] ivl_q, ivl_d;
  logic [CW_W-1:0]  fix_q, fix_d;
  logic [CNT_W-1:0] fcnt_q, fcnt_d;
  logic [CNT_W-1:0] bcnt_q, bcnt_d;
  logic [AW-1:0]    badr_q, badr_d;
  logic             done_q, done_d;
  logic             adv;
  logic             hit;

  assign hit = busy && busy_we && (busy_addr == addr_q);

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    ivl_d  = ivl_q;
    fix_d  = fix_q;
    fcnt_d = fcnt_q;
    bcnt_d = bcnt_q;
    badr_d = badr_q;
    done_d = 1'b0;
    rd_go  = 1'b0;
    wr_go  = 1'b0;
    adv    = 1'b0;
    case (st_q)
      SW_WAIT: begin
        if (!en) begin
          ivl_d = '0;
        end else if (!busy) begin
          if (ivl_q >= gap) begin
            rd_go = 1'b1;
            st_d  = SW_CHECK;
          end else begin
            ivl_d = ivl_q + IVL_W'(1);
          end
        end
      end
      SW_CHECK: begin
        if (dec_sbe) begin
          if (fcnt_q != '1) fcnt_d = fcnt_q + CNT_W'(1);
          if (hit) begin
            adv = 1'b1;
          end else begin
            fix_d = dec_cw;
            st_d  = SW_FIX;
          end
        end else begin
          if (dec_dbe) begin
            if (bcnt_q != '1) bcnt_d = bcnt_q + CNT_W'(1);
            badr_d = addr_q;
          end
          adv = 1'b1;
        end
      end
      SW_FIX: begin
        if (hit) begin
          adv = 1'b1;
        end else if (!busy) begin
          wr_go = 1'b1;
          adv   = 1'b1;
        end
      end
      default: st_d = SW_WAIT;
    endcase
    if (adv) begin
      st_d   = SW_WAIT;
      ivl_d  = '0;
      addr_d = (addr_q == LAST) ? '0 : addr_q + AW'(1);
      done_d = (addr_q == LAST);
    end
    if (clr) begin
      fcnt_d = '0;
      bcnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SW_WAIT;
      addr_q <= '0;
      ivl_q  <= '0;
      fix_q  <= '0;
      fcnt_q <= '0;
      bcnt_q <= '0;
      badr_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      ivl_q  <= ivl_d;
      fcnt_q <= fcnt_d;
      bcnt_q <= bcnt_d;
      badr_q <= badr_d;
      done_q <= done_d;
      if (st_q == SW_CHECK) fix_q <= fix_d;
    end
  end

  assign addr     = addr_q;
  assign wr_cw    = fix_q;
  assign fix_cnt  = fcnt_q;
  assign bad_cnt  = bcnt_q;
  assign bad_addr = badr_q;
  assign done     = done_q;

endmodule

// File: rtl/ecc_scrub_mem.sv
module ecc_scrub_mem
  import ecc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 128,
  parameter int STRIDE = 8,
  parameter int IVL_W  = 16,
  parameter int CNT_W  = 16,
  localparam int CHK_W = chk_bits(DATA_W),
  localparam int CW_W  = DATA_W + CHK_W + 1,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              usr_req,
  input  logic              usr_we,
  input  logic [AW-1:0]     usr_addr,
  input  logic [DATA_W-1:0] usr_wdata,
  input  logic [CW_W-1:0]   usr_inj,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_sbe,
  output logic              rd_dbe,
  input  logic              scrub_en,
  input  logic [IVL_W-1:0]  scrub_gap,
  input  logic              count_clr,
  output logic [CNT_W-1:0]  fix_count,
  output logic [CNT_W-1:0]  bad_count,
  output logic [AW-1:0]     bad_addr,
  output logic              sweep_done
);

  logic [CW_W-1:0] enc_cw, log_wr, phys_wr, phys_rd, log_rd, dec_fixed, sw_cw;
  logic            dec_sbe, dec_dbe;
  logic            sw_rd_go, sw_wr_go;
  logic [AW-1:0]   sw_addr;
  logic            mem_we, mem_re;
  logic [AW-1:0]   mem_addr;
  logic            rdv_q, rdv_d;

  ecc_encode #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CW_W(CW_W)) u_enc (
    .data (usr_wdata),
    .cw   (enc_cw)
  );

  // port arbitration: user first, refresher only on a free cycle
  assign log_wr   = usr_req ? enc_cw : sw_cw;
  assign mem_we   = usr_req ? usr_we : sw_wr_go;
  assign mem_re   = usr_req ? !usr_we : sw_rd_go;
  assign mem_addr = usr_req ? usr_addr : sw_addr;

  ecc_interleave #(.CW_W(CW_W), .STRIDE(STRIDE), .UNDO(1'b0)) u_scatter (
    .din  (log_wr),
    .dout (phys_wr)
  );

  ecc_store #(.CW_W(CW_W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .re    (mem_re),
    .addr  (mem_addr),
    .wdata (phys_wr ^ (usr_req ? usr_inj : '0)),
    .rdata (phys_rd)
  );

  ecc_interleave #(.CW_W(CW_W), .STRIDE(STRIDE), .UNDO(1'b1)) u_gather (
    .din  (phys_rd),
    .dout (log_rd)
  );

  ecc_decode #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CW_W(CW_W)) u_dec (
    .cw    (log_rd),
    .fixed (dec_fixed),
    .data  (rd_data),
    .sbe   (dec_sbe),
    .dbe   (dec_dbe)
  );

  ecc_sweeper #(
    .CW_W(CW_W), .DEPTH(DEPTH), .AW(AW), .IVL_W(IVL_W), .CNT_W(CNT_W)
  ) u_sweep (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (scrub_en),
    .gap       (scrub_gap),
    .busy      (usr_req),
    .busy_we   (usr_we),
    .busy_addr (usr_addr),
    .dec_sbe   (dec_sbe),
    .dec_dbe   (dec_dbe),
    .dec_cw    (dec_fixed),
    .clr       (count_clr),
    .rd_go     (sw_rd_go),
    .wr_go     (sw_wr_go),
    .addr      (sw_addr),
    .wr_cw     (sw_cw),
    .fix_cnt   (fix_count),
    .bad_cnt   (bad_count),
    .bad_addr  (bad_addr),
    .done      (sweep_done)
  );

  assign rdv_d = usr_req && !usr_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdv_q <= 1'b0;
    else        rdv_q <= rdv_d;
  end

  assign rd_valid = rdv_q;
  assign rd_sbe   = rdv_q && dec_sbe;
  assign rd_dbe   = rdv_q && dec_dbe;

endmodule

// File: rtl/ecc_scrub_mem_chk.sv
module ecc_scrub_mem_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             usr_req,
  input logic             usr_we,
  input logic             rd_valid,
  input logic             rd_sbe,
  input logic             rd_dbe,
  input logic             count_clr,
  input logic [CNT_W-1:0] fix_count,
  input logic [CNT_W-1:0] bad_count,
  input logic             sweep_done,
  input logic             scrub_rd,
  input logic             scrub_wr
);

  // R4
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (usr_req && !usr_we) |=> rd_valid);

  // R4
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(usr_req && !usr_we) |=> !rd_valid);

  // R4
  flag_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sbe || rd_dbe) |-> rd_valid);

  // R1
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_sbe, rd_dbe}));

  // R8
  user_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    usr_req |-> (!scrub_rd && !scrub_wr));

  // R11
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_clr |=> (fix_count == '0) && (bad_count == '0));

  // R10
  fix_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !count_clr |=> (fix_count == $past(fix_count)) ||
                   (fix_count == $past(fix_count) + CNT_W'(1)));

  // R10
  bad_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !count_clr |=> (bad_count == $past(bad_count)) ||
                   (bad_count == $past(bad_count) + CNT_W'(1)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |=> !sweep_done);

endmodule

bind ecc_scrub_mem ecc_scrub_mem_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .usr_req    (usr_req),
  .usr_we     (usr_we),
  .rd_valid   (rd_valid),
  .rd_sbe     (rd_sbe),
  .rd_dbe     (rd_dbe),
  .count_clr  (count_clr),
  .fix_count  (fix_count),
  .bad_count  (bad_count),
  .sweep_done (sweep_done),
  .scrub_rd   (sw_rd_go),
  .scrub_wr   (sw_wr_go)
);

// File: tb/test_ecc_scrub_mem.sv
module test_ecc_scrub_mem;

  localparam int DW    = 32;
  localparam int DEPTH = 128;
  localparam int CW    = 39;
  localparam int AW    = 7;
  localparam int CNTW  = 3;

  logic            clk;
  logic            rst_n;
  logic            usr_req;
  logic            usr_we;
  logic [AW-1:0]   usr_addr;
  logic [DW-1:0]   usr_wdata;
  logic [CW-1:0]   usr_inj;
  logic            rd_valid;
  logic [DW-1:0]   rd_data;
  logic            rd_sbe;
  logic            rd_dbe;
  logic            scrub_en;
  logic [15:0]     scrub_gap;
  logic            count_clr;
  logic [CNTW-1:0] fix_count;
  logic [CNTW-1:0] bad_count;
  logic [AW-1:0]   bad_addr;
  logic            sweep_done;

  ecc_scrub_mem #(.CNT_W(CNTW)) i_ecc_scrub_mem (
    .clk(clk), .rst_n(rst_n), .usr_req(usr_req), .usr_we(usr_we),
    .usr_addr(usr_addr), .usr_wdata(usr_wdata), .usr_inj(usr_inj),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_sbe(rd_sbe), .rd_dbe(rd_dbe),
    .scrub_en(scrub_en), .scrub_gap(scrub_gap), .count_clr(count_clr),
    .fix_count(fix_count), .bad_count(bad_count), .bad_addr(bad_addr),
    .sweep_done(sweep_done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  bit finished = 0;

  // behavioural reference: stored data and number of flipped cells per word
  logic [DW-1:0] m_data [DEPTH];
  int            m_err  [DEPTH];
  logic          pend_v;
  logic [AW-1:0] pend_a;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    pend_v <= rst_n && usr_req && !usr_we;
    pend_a <= usr_addr;
    if (rst_n && usr_req && usr_we) begin
      m_data[usr_addr] = usr_wdata;
      m_err[usr_addr]  = $countones(usr_inj);
    end
  end

  // per-cycle comparison of the read port against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 valid", {31'b0, rd_valid}, {31'b0, pend_v});
      if (pend_v) begin
        automatic int e = m_err[pend_a];
        automatic string tag = (e == 0) ? "R3" : (e == 1) ? "R1" : "R2";
        chk(tag, {30'b0, rd_sbe, rd_dbe}, {30'b0, (e == 1), (e >= 2)});
        if (e < 2) chk(tag, rd_data, m_data[pend_a]);
      end else begin
        chk("R4 flags", {30'b0, rd_sbe, rd_dbe}, 32'd0);
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    usr_req = 1'b0; usr_we = 1'b0; usr_inj = '0; count_clr = 1'b0;
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d, input logic [CW-1:0] m);
    @(negedge clk);
    usr_req = 1'b1; usr_we = 1'b1; usr_addr = AW'(a); usr_wdata = d; usr_inj = m;
  endtask

  task automatic rd(input int a);
    @(negedge clk);
    usr_req = 1'b1; usr_we = 1'b0; usr_addr = AW'(a); usr_inj = '0;
  endtask

  // runs until sweep_done; optionally stops the refresher on the pulse cycle
  task automatic run_sweep(input bit traffic, input bit stop, output int t);
    int k;
    k = 0;
    forever begin
      @(negedge clk);
      if (sweep_done) begin
        usr_req = 1'b0;
        if (stop) scrub_en = 1'b0;
        t = cyc;
        for (int a = 0; a < DEPTH; a++) if (m_err[a] == 1) m_err[a] = 0;
        break;
      end
      if (traffic && (k % 3) != 2) begin
        usr_req = 1'b1; usr_we = 1'b0; usr_addr = AW'(100 + (k % 20));
      end else begin
        usr_req = 1'b0;
      end
      k++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
  end

  initial begin
    int t1, t2;
    rst_n = 1'b0; usr_req = 1'b0; usr_we = 1'b0; usr_addr = '0; usr_wdata = '0;
    usr_inj = '0; scrub_en = 1'b0; scrub_gap = '0; count_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R13 rd_valid", {31'b0, rd_valid}, 32'd0);
    chk("R13 sweep_done", {31'b0, sweep_done}, 32'd0);
    chk("R13 fix_count", {29'b0, fix_count}, 32'd0);
    chk("R13 bad_count", {29'b0, bad_count}, 32'd0);
    chk("R13 bad_addr", {25'b0, bad_addr}, 32'd0);
    rst_n = 1'b1;

    for (int a = 0; a < DEPTH; a++) wr(a, (a * 32'h9E3779B9) ^ 32'h5A5A0000, '0);
    rd(0); rd(1); rd(127); idle(); idle();

    // R9: clean array, no traffic, gap of 2 -> 128*4 cycles per pass
    scrub_gap = 16'd2; scrub_en = 1'b1;
    run_sweep(1'b0, 1'b0, t1);
    run_sweep(1'b0, 1'b1, t2);
    chk("R9 period", t2 - t1, DEPTH * 4);
    chk("R10 clean fix_count", {29'b0, fix_count}, 32'd0);
    chk("R10 clean bad_count", {29'b0, bad_count}, 32'd0);

    // single and double upsets through the injection mask
    wr(5, 32'h0000_0000, 39'd1);
    wr(6, 32'hFFFF_FFFF, 39'd1 << 38);
    wr(7, 32'h1234_5678, 39'd1 << 20);
    wr(10, 32'hA5A5_A5A5, (39'd1 << 3) | (39'd1 << 4));
    wr(50, 32'h0000_0000, 39'd1 | (39'd1 << 38));
    rd(5); rd(6); rd(7); rd(50);
    rd(10); idle();
    chk("R5 adjacent cells", {30'b0, rd_sbe, rd_dbe}, 32'd1);
    rd(5); idle();
    chk("R6 still single", {31'b0, rd_sbe}, 32'd1);
    idle();

    // R7/R8: full pass with dense user reads on clean words
    scrub_gap = 16'd0; scrub_en = 1'b1;
    run_sweep(1'b1, 1'b1, t1);
    idle();
    chk("R8 no skip", {29'b0, fix_count}, 32'd3);
    chk("R10 bad_count", {29'b0, bad_count}, 32'd2);
    chk("R12 bad_addr", {25'b0, bad_addr}, 32'd50);
    rd(5); idle();
    chk("R7 repaired", {30'b0, rd_sbe, rd_dbe}, 32'd0);
    rd(6); rd(7); rd(10); idle();
    chk("R12 left bad", {30'b0, rd_sbe, rd_dbe}, 32'd1);

    // R11: clear
    @(negedge clk); count_clr = 1'b1;
    @(negedge clk); count_clr = 1'b0;
    chk("R11 fix_count", {29'b0, fix_count}, 32'd0);
    chk("R11 bad_count", {29'b0, bad_count}, 32'd0);

    // R10: saturation with ten repairable words
    for (int a = 60; a < 70; a++) wr(a, 32'hC3C3_0000 | 32'(a), 39'd1 << ((a * 7) % CW));
    idle();
    scrub_gap = 16'd1; scrub_en = 1'b1;
    run_sweep(1'b0, 1'b1, t1);
    idle();
    chk("R10 saturate", {29'b0, fix_count}, 32'd7);
    chk("R10 bad recount", {29'b0, bad_count}, 32'd2);
    chk("R12 bad_addr again", {25'b0, bad_addr}, 32'd50);
    rd(60); rd(65); rd(69); idle(); idle();

    report();
  end

endmodule